// File: doc/BRIEF.md
# PRG/CHR Bank Address Translator

This block sits between a cartridge's bank-control registers and its memories. It reads four 5-bit control words: a mode word, two pattern-bank words and a program-bank word. From them it turns a CPU address in the upper 32 KB window into a physical program-ROM address, and a 13-bit video pattern address into a physical pattern-memory address. It also produces the nametable page bit for the current nametable quadrant, a work-RAM enable and a work-RAM bank number.

The program window has three layouts. In the first, one 32 KB bank is switched. In the second, the lower 16 KB half is switched and the upper half is fixed to the last bank. In the third, the lower half is fixed to the first bank and the upper half is switched. When the ROM holds more than sixteen 16 KB banks, bit 4 of whichever pattern-bank word was written last becomes a fifth program-bank bit. That bit applies to the fixed banks as well as to the switched ones. The same pattern-bank word also supplies the work-RAM bank bits, masked down to the banks that are fitted.

The translation is combinational. A parameter adds one register stage on every output.

Top module: `bank_xlate`

## Requirements
- R1: `nt_page` follows `mode_reg[1:0]`: 0 gives 0, 1 gives 1, 2 gives `nt_quad[0]` (vertical), and 3 gives `nt_quad[1]` (horizontal).
- R2: When `mode_reg[3]`=0, `prg_addr` = {hb, `prg_reg[3:1]`, `cpu_addr[14:0]`}. This is one 32 KB bank.
- R3: When `mode_reg[3:2]`=11, `cpu_addr[14]`=0 selects bank `prg_reg[3:0]` and `cpu_addr[14]`=1 selects bank 0xF. `prg_addr` = {hb, bank, `cpu_addr[13:0]`}.
- R4: When `mode_reg[3:2]`=10, `cpu_addr[14]`=0 selects bank 0 and `cpu_addr[14]`=1 selects bank `prg_reg[3:0]`. The address is formed as in R3.
- R5: With `PRG_BANKS16` > 16, hb (bit 18 of `prg_addr`) is bit 4 of `chr_reg_b` when `chr_b_last`=1, and bit 4 of `chr_reg_a` otherwise. It is applied in every layout. Otherwise hb is 0.
- R6: When `mode_reg[4]`=0, `chr_addr` = {`chr_reg_a[4:1]`, `ppu_addr[12:0]`}. This is one 8 KB bank.
- R7: When `mode_reg[4]`=1, `chr_addr` = {`ppu_addr[12]` ? `chr_reg_b` : `chr_reg_a`, `ppu_addr[11:0]`}.
- R8: `wram_en` is 1 exactly when `prg_reg[4]`=0.
- R9: `wram_bank` = (selected pattern word & mask) >> 3. The selected word is chosen by `chr_b_last` as in R5. The mask is 0x08 when hb is in use and 0x18 otherwise, and it is ANDed with (`RAM_BANKS`-1)<<3. With the defaults, `wram_bank` = {0, word[3]}.
- R10: With `REG_OUT`=1, each output reflects the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 5 | Mirroring, program layout and pattern layout |
| chr_reg_a | input | 5 | Pattern bank word for 0x0000 |
| chr_reg_b | input | 5 | Pattern bank word for 0x1000 |
| prg_reg | input | 5 | Program bank and work-RAM disable |
| chr_b_last | input | 1 | 1 when `chr_reg_b` was the last pattern word written |
| cpu_addr | input | 16 | CPU address |
| ppu_addr | input | 13 | Video pattern address |
| nt_quad | input | 2 | Nametable quadrant being accessed |
| prg_addr | output | 19 | Physical program-ROM address |
| chr_addr | output | 17 | Physical pattern-memory address |
| nt_page | output | 1 | Nametable page select |
| wram_en | output | 1 | Work-RAM enable |
| wram_bank | output | 2 | Work-RAM bank |

## Verification
The high-bank-bit logic and the fixed-bank logic both act on the same program bank number in the same cycle. When a fixed bank (0 or 0xF) is selected while hb is 1, both are exercised at once. The bench drives that case in both 16 KB layouts and with each pattern word as the source. It checks that the fixed bank appears at 0x10 or 0x1F rather than at its bare value. It also flips `chr_b_last` on its own and observes that hb and `wram_bank` move together.

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int PRG_BANKS16 = 32,
  parameter int CHR_BANKS4  = 32,
  parameter int RAM_BANKS   = 4,
  parameter bit REG_OUT     = 1'b1,
  localparam int PRG_AW = 14 + $clog2(PRG_BANKS16),
  localparam int CHR_AW = 12 + $clog2(CHR_BANKS4),
  localparam int RAM_BW = (RAM_BANKS > 2) ? $clog2(RAM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_reg,
  input  logic [4:0]        chr_reg_a,
  input  logic [4:0]        chr_reg_b,
  input  logic [4:0]        prg_reg,
  input  logic              chr_b_last,
  input  logic [15:0]       cpu_addr,
  input  logic [12:0]       ppu_addr,
  input  logic [1:0]        nt_quad,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              nt_page,
  output logic              wram_en,
  output logic [RAM_BW-1:0] wram_bank
);
  localparam bit       HI_EN    = PRG_BANKS16 > 16;
  localparam int       RAM_TOP  = (RAM_BANKS > 0) ? RAM_BANKS - 1 : 0;
  localparam logic [4:0] RAM_MASK = (HI_EN ? 5'h08 : 5'h18) & 5'(RAM_TOP << 3);

  logic [4:0]  last_chr;
  logic        hb;
  logic [3:0]  bank16;
  logic [18:0] prg_full;
  logic [16:0] chr_full;
  logic        page_c;
  logic [1:0]  ram_full;

  assign last_chr = chr_b_last ? chr_reg_b : chr_reg_a;
  assign hb       = HI_EN & last_chr[4];
  assign ram_full = 2'((last_chr & RAM_MASK) >> 3);

  always_comb begin
    if (cpu_addr[14]) bank16 = mode_reg[2] ? 4'hF : prg_reg[3:0];
    else              bank16 = mode_reg[2] ? prg_reg[3:0] : 4'h0;
  end

  assign prg_full = mode_reg[3] ? {hb, bank16, cpu_addr[13:0]}
                                : {hb, prg_reg[3:1], cpu_addr[14:0]};

  assign chr_full = mode_reg[4] ? {(ppu_addr[12] ? chr_reg_b : chr_reg_a), ppu_addr[11:0]}
                                : {chr_reg_a[4:1], ppu_addr[12:0]};

  always_comb begin
    unique case (mode_reg[1:0])
      2'd0: page_c = 1'b0;
      2'd1: page_c = 1'b1;
      2'd2: page_c = nt_quad[0];
      default: page_c = nt_quad[1];
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prg_addr  <= '0;
          chr_addr  <= '0;
          nt_page   <= 1'b0;
          wram_en   <= 1'b0;
          wram_bank <= '0;
        end else begin
          prg_addr  <= prg_full[PRG_AW-1:0];
          chr_addr  <= chr_full[CHR_AW-1:0];
          nt_page   <= page_c;
          wram_en   <= ~prg_reg[4];
          wram_bank <= ram_full[RAM_BW-1:0];
        end
      end
    end else begin : g_comb
      assign prg_addr  = prg_full[PRG_AW-1:0];
      assign chr_addr  = chr_full[CHR_AW-1:0];
      assign nt_page   = page_c;
      assign wram_en   = ~prg_reg[4];
      assign wram_bank = ram_full[RAM_BW-1:0];
    end
  endgenerate
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter bit REG_OUT = 1'b1,
  parameter int PRG_AW  = 19,
  parameter int CHR_AW  = 17,
  parameter int RAM_BW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_reg,
  input logic [4:0]        prg_reg,
  input logic [15:0]       cpu_addr,
  input logic [12:0]       ppu_addr,
  input logic [1:0]        nt_quad,
  input logic [PRG_AW-1:0] prg_addr,
  input logic [CHR_AW-1:0] chr_addr,
  input logic              nt_page,
  input logic              wram_en,
  input logic [RAM_BW-1:0] wram_bank
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  generate
    if (REG_OUT && PRG_AW >= 18 && CHR_AW >= 13) begin : g_seq
      assert_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> nt_page == ($past(mode_reg[1]) ? $past(nt_quad[~mode_reg[0]] ) : $past(mode_reg[0]))
        || (primed && $past(mode_reg[1]) && nt_page == (($past(mode_reg[0])) ? $past(nt_quad[1]) : $past(nt_quad[0]))));
      assert_prg32_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(mode_reg[3])) |->
          (prg_addr[17:15] == $past(prg_reg[3:1]) && prg_addr[14:0] == $past(cpu_addr[14:0])));
      assert_fix_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_reg[3] && mode_reg[2] && cpu_addr[14])) |-> prg_addr[17:14] == 4'hF);
      assert_fix_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_reg[3] && !mode_reg[2] && !cpu_addr[14])) |-> prg_addr[17:14] == 4'h0);
      assert_chr8_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(mode_reg[4])) |-> chr_addr[12:0] == $past(ppu_addr));
      assert_wram_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> wram_en == !$past(prg_reg[4]));
      assert_reset_R10: assert property (@(posedge clk)
        !rst_n |-> (prg_addr == '0 && wram_en == 1'b0 && wram_bank == '0));
    end else begin : g_imm
      always_comb if (rst_n) assert_wram_en_comb_R8: assert (wram_en == !prg_reg[4]);
    end
  endgenerate
endmodule

bind bank_xlate bank_xlate_chk #(
  .REG_OUT(REG_OUT), .PRG_AW(PRG_AW), .CHR_AW(CHR_AW), .RAM_BW(RAM_BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .prg_reg(prg_reg),
  .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .nt_quad(nt_quad),
  .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_page(nt_page),
  .wram_en(wram_en), .wram_bank(wram_bank)
);

// File: tb/bank_xlate_bench.sv
module bank_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_reg = '0, chr_reg_a = '0, chr_reg_b = '0, prg_reg = '0;
  logic        chr_b_last = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic [1:0]  nt_quad = '0;
  logic [18:0] prg_addr;
  logic [16:0] chr_addr;
  logic        nt_page, wram_en;
  logic [1:0]  wram_bank;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_xlate u_bank_xlate (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .chr_reg_a(chr_reg_a),
    .chr_reg_b(chr_reg_b), .prg_reg(prg_reg), .chr_b_last(chr_b_last),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .nt_quad(nt_quad),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_page(nt_page),
    .wram_en(wram_en), .wram_bank(wram_bank)
  );

  typedef struct packed {
    logic [4:0]  md;
    logic [4:0]  ca;
    logic [4:0]  cb;
    logic [4:0]  pr;
    logic        bl;
    logic [15:0] cpu;
    logic [12:0] ppu;
    logic [1:0]  q;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5'h00, 5'h06, 5'h01, 5'h07, 1'b0, 16'hFFFF, 13'h1ABC, 2'b01}, // R2 R6 R1
    '{5'h01, 5'h13, 5'h02, 5'h0A, 1'b0, 16'h8123, 13'h0042, 2'b10}, // R2 R5
    '{5'h0E, 5'h00, 5'h00, 5'h05, 1'b0, 16'h8456, 13'h0FFF, 2'b01}, // R3 R1
    '{5'h0E, 5'h00, 5'h10, 5'h05, 1'b1, 16'hC001, 13'h1000, 2'b11}, // R3 R5
    '{5'h0B, 5'h18, 5'h00, 5'h09, 1'b0, 16'h8000, 13'h0777, 2'b10}, // R4 R1
    '{5'h0B, 5'h00, 5'h00, 5'h09, 1'b0, 16'hFFFE, 13'h1777, 2'b01}, // R4
    '{5'h1C, 5'h0C, 5'h15, 5'h13, 1'b0, 16'hA000, 13'h0123, 2'b00}, // R7 R8
    '{5'h1C, 5'h0C, 5'h15, 5'h03, 1'b1, 16'hE000, 13'h1123, 2'b00}, // R7 R9
    '{5'h02, 5'h1F, 5'h08, 5'h1F, 1'b1, 16'h9FFF, 13'h1FFF, 2'b11}, // R2 R8 R9
    '{5'h03, 5'h08, 5'h17, 5'h00, 1'b0, 16'h4000, 13'h0000, 2'b10}, // R1 R9
    '{5'h08, 5'h10, 5'h00, 5'h0F, 1'b0, 16'h8001, 13'h0001, 2'b01}, // R4 R5
    '{5'h0C, 5'h00, 5'h1F, 5'h0F, 1'b1, 16'hBFFF, 13'h1001, 2'b10}  // R3 R5
  };

  function automatic logic [18:0] exp_prg(vec_t v);
    logic hb = v.bl ? v.cb[4] : v.ca[4];
    logic [3:0] b;
    if (!v.md[3]) return {hb, v.pr[3:1], v.cpu[14:0]};
    if (v.cpu[14]) b = v.md[2] ? 4'hF : v.pr[3:0];
    else           b = v.md[2] ? v.pr[3:0] : 4'h0;
    return {hb, b, v.cpu[13:0]};
  endfunction

  function automatic logic [16:0] exp_chr(vec_t v);
    if (!v.md[4]) return {v.ca[4:1], v.ppu};
    return {v.ppu[12] ? v.cb : v.ca, v.ppu[11:0]};
  endfunction

  function automatic logic exp_page(vec_t v);
    case (v.md[1:0])
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return v.q[0];
      default: return v.q[1];
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    mode_reg = v.md; chr_reg_a = v.ca; chr_reg_b = v.cb; prg_reg = v.pr;
    chr_b_last = v.bl; cpu_addr = v.cpu; ppu_addr = v.ppu; nt_quad = v.q;
    @(negedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mode_reg = 5'h0E; prg_reg = 5'h03; cpu_addr = 16'hC000; chr_reg_a = 5'h1F;
    #12;
    check("R10 reset prg_addr", 32'(prg_addr), 0);
    check("R10 reset wram_en", 32'(wram_en), 0);
    check("R10 reset wram_bank", 32'(wram_bank), 0);
    check("R10 reset chr_addr", 32'(chr_addr), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check("R2/R3/R4/R5 prg_addr", 32'(prg_addr), 32'(exp_prg(VEC[i])));
      check("R6/R7 chr_addr", 32'(chr_addr), 32'(exp_chr(VEC[i])));
      check("R1 nt_page", 32'(nt_page), 32'(exp_page(VEC[i])));
      check("R8 wram_en", 32'(wram_en), 32'(!VEC[i].pr[4]));
      check("R9 wram_bank", 32'(wram_bank),
            32'({1'b0, VEC[i].bl ? VEC[i].cb[3] : VEC[i].ca[3]}));
    end

    // R3 with R5: fixed last bank carries the high bit -> 0x1F
    apply('{5'h0C, 5'h1F, 5'h00, 5'h05, 1'b0, 16'hC123, 13'h0, 2'b0});
    check("R3 R5 fixed-last high", 32'(prg_addr), 32'h7C123);
    // R4 with R5: fixed first bank carries the high bit -> 0x10
    apply('{5'h08, 5'h10, 5'h00, 5'h05, 1'b0, 16'h8001, 13'h0, 2'b0});
    check("R4 R5 fixed-first high", 32'(prg_addr), 32'h40001);
    // R2: 32 KB mode, prg_reg bit 0 ignored
    apply('{5'h00, 5'h00, 5'h00, 5'h07, 1'b0, 16'hFFFF, 13'h0, 2'b0});
    check("R2 32k bank ignores bit0", 32'(prg_addr), 32'h1FFFF);
    // R5 + R9: flipping only chr_b_last moves hb and wram bank together
    apply('{5'h0C, 5'h00, 5'h18, 5'h02, 1'b0, 16'h8000, 13'h0, 2'b0});
    check("R5 source a", 32'(prg_addr), 32'h08000);
    check("R9 source a", 32'(wram_bank), 0);
    apply('{5'h0C, 5'h00, 5'h18, 5'h02, 1'b1, 16'h8000, 13'h0, 2'b0});
    check("R5 source b", 32'(prg_addr), 32'h48000);
    check("R9 source b", 32'(wram_bank), 1);
    // R10: output holds old value until the next edge
    @(negedge clk); prg_reg = 5'h12; #1;
    check("R10 latency hold", 32'(wram_en), 1);
    @(negedge clk);
    check("R10 latency update", 32'(wram_en), 0);
    // R10: async reset clears outputs mid-run
    rst_n = 1'b0; #1;
    check("R10 reset mid-run", 32'(prg_addr), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule